// File: doc/BRIEF.md
# Intra-Group Store-Load Conflict Detector

This block sits beside an instruction grouping stage. While a dispatch group is being assembled, every store placed in the group is written into a small table. Each entry holds a symbolic base-register tag, a signed byte offset from that base and an access size in bytes. Every load offered to the same group is compared against all live entries in a single cycle. If the load may read bytes that a recorded store writes, the block raises a no-op request. The grouping stage then closes the group with filler and issues the load in the next group.

Addresses are never resolved here. Two accesses are candidates for a conflict only when they use the same base tag. The comparison is then an overlap test on offset ranges. The table empties when the group ends or when the block is reset. The conflict output is purely combinational from the load query. Stores are recorded on the clock edge.

Top module: `sld_conflict_detector`

## Requirements
- R1: The table holds at most DEPTH (default 4) stores per group. A store offered while the table is full is dropped, and a later load that matches only that dropped store gives no conflict.
- R2: A store is recorded on the rising clock edge. A load presented in the same cycle as the store does not see it. A load in any later cycle of the same group does see it.
- R3: A load whose tag and offset both equal those of a live entry conflicts, whatever the two sizes are (zero included).
- R4: Same tag, store offset lower than load offset: the load conflicts exactly when store offset plus store size is greater than the load offset.
- R5: Same tag, store offset higher than load offset: the load conflicts exactly when load offset plus load size is greater than the store offset.
- R6: A load never conflicts with an entry whose tag differs from the load tag.
- R7: When grp_end is high, the table is emptied on that clock edge. A store offered in the same cycle is not recorded. A load in that cycle is still checked against the old contents.
- R8: While rst_n is low, the table is empty, and it stays empty after release until a store is recorded.
- R9: noop_req is 0 whenever ld_valid is 0, and whenever no store is recorded in the current group.
- R10: Offsets are 16-bit two's complement and sizes are 4-bit unsigned byte counts. The offset-plus-size sums are formed one bit wider, so no sum wraps. For example, a store at 32766 of size 15 conflicts with a load at 32767.
- R11: noop_req is combinational: it follows the load query in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| st_valid | input | 1 | Store record strobe |
| st_tag | input | TAG_W | Base-register tag of the store |
| st_off | input | OFF_W | Signed byte offset of the store |
| st_size | input | SIZE_W | Store size in bytes |
| grp_end | input | 1 | Current dispatch group closes at this edge |
| ld_valid | input | 1 | Load query strobe |
| ld_tag | input | TAG_W | Base-register tag of the load |
| ld_off | input | OFF_W | Signed byte offset of the load |
| ld_size | input | SIZE_W | Load size in bytes |
| noop_req | output | 1 | Load conflicts with a recorded store; filler needed |

## Verification
The bench probes the half-open overlap boundaries in both directions, where the end of one range lands exactly on the start of the other. A design using >= instead of > would flag touching ranges. It covers equal offsets with zero sizes, which a design relying only on the range test would miss. It checks offsets near the 16-bit limits, where a sum of native width would wrap and hide a real overlap. It also covers the fifth store of a group, a store and a load in the same cycle, and a store together with grp_end. Wrong priority or wrong timing in any of these shows up as a spurious or missing noop_req. Random traffic over a few tags and a narrow offset window is checked against a reference model computed in the bench.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned SLD_TAG_W  = 5;
  localparam int unsigned SLD_OFF_W  = 16;
  localparam int unsigned SLD_SIZE_W = 4;
  localparam int unsigned SLD_DEPTH  = 4;

  // Outcome of comparing one load against one table slot
  typedef enum logic [1:0] {
    MATCH_NONE       = 2'd0,
    MATCH_EXACT      = 2'd1,
    MATCH_LOW_STORE  = 2'd2,
    MATCH_HIGH_STORE = 2'd3
  } match_kind_e;
endpackage

// File: rtl/sld_slot_compare.sv
module sld_slot_compare
  import sld_pkg::*;
#(
  parameter int unsigned TAG_W  = SLD_TAG_W,
  parameter int unsigned OFF_W  = SLD_OFF_W,
  parameter int unsigned SIZE_W = SLD_SIZE_W
) (
  input  logic              slot_live,
  input  logic [TAG_W-1:0]  s_tag,
  input  logic [OFF_W-1:0]  s_off,
  input  logic [SIZE_W-1:0] s_size,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [OFF_W-1:0]  l_off,
  input  logic [SIZE_W-1:0] l_size,
  output match_kind_e       kind
);
  localparam int unsigned EXT_W = OFF_W + 1;

  logic signed [EXT_W-1:0] s_base, l_base, s_len, l_len, s_end, l_end;

  // Sign-extend offsets by one bit so offset+size never wraps
  always_comb begin
    s_base = {s_off[OFF_W-1], s_off};
    l_base = {l_off[OFF_W-1], l_off};
    s_len  = {{(EXT_W-SIZE_W){1'b0}}, s_size};
    l_len  = {{(EXT_W-SIZE_W){1'b0}}, l_size};
    s_end  = s_base + s_len;
    l_end  = l_base + l_len;
  end

  always_comb begin
    kind = MATCH_NONE;
    if (slot_live && (s_tag == l_tag)) begin
      if (s_off == l_off) begin
        kind = MATCH_EXACT;
      end else if (s_base < l_base) begin
        if (s_end > l_base) kind = MATCH_LOW_STORE;
      end else begin
        if (l_end > s_base) kind = MATCH_HIGH_STORE;
      end
    end
  end
endmodule

// File: rtl/sld_store_table.sv
module sld_store_table
  import sld_pkg::*;
#(
  parameter int unsigned TAG_W  = SLD_TAG_W,
  parameter int unsigned OFF_W  = SLD_OFF_W,
  parameter int unsigned SIZE_W = SLD_SIZE_W,
  parameter int unsigned DEPTH  = SLD_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          st_valid,
  input  logic [TAG_W-1:0]              st_tag,
  input  logic [OFF_W-1:0]              st_off,
  input  logic [SIZE_W-1:0]             st_size,
  input  logic                          grp_end,
  output logic [DEPTH-1:0]              slot_live,
  output logic [DEPTH-1:0][TAG_W-1:0]   slot_tag,
  output logic [DEPTH-1:0][OFF_W-1:0]   slot_off,
  output logic [DEPTH-1:0][SIZE_W-1:0]  slot_size,
  output logic [CNT_W-1:0]              fill_cnt
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rec_en;
  logic [DEPTH-1:0] slot_we;

  // Next state: clear has priority over recording
  always_comb begin
    rec_en = st_valid && !grp_end && (cnt_q < DEPTH_C);
    cnt_d  = cnt_q;
    if (grp_end)     cnt_d = '0;
    else if (rec_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_comb begin
        slot_we[gi]   = rec_en && (cnt_q == CNT_W'(gi));
        slot_live[gi] = (CNT_W'(gi) < cnt_q);
      end

      // Payload registers carry no reset; liveness comes from cnt_q
      always_ff @(posedge clk) begin
        if (slot_we[gi]) begin
          slot_tag[gi]  <= st_tag;
          slot_off[gi]  <= st_off;
          slot_size[gi] <= st_size;
        end
      end
    end
  endgenerate

  assign fill_cnt = cnt_q;

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);

  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == DEPTH_C && !grp_end) |=> cnt_q == DEPTH_C);

  p_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !grp_end && cnt_q < DEPTH_C) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end |=> cnt_q == '0);
endmodule

// File: rtl/sld_conflict_detector.sv
module sld_conflict_detector
  import sld_pkg::*;
#(
  parameter int unsigned TAG_W  = SLD_TAG_W,
  parameter int unsigned OFF_W  = SLD_OFF_W,
  parameter int unsigned SIZE_W = SLD_SIZE_W,
  parameter int unsigned DEPTH  = SLD_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              grp_end,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [SIZE_W-1:0] ld_size,
  output logic              noop_req
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             slot_live;
  logic [DEPTH-1:0][TAG_W-1:0]  slot_tag;
  logic [DEPTH-1:0][OFF_W-1:0]  slot_off;
  logic [DEPTH-1:0][SIZE_W-1:0] slot_size;
  logic [CNT_W-1:0]             fill_cnt;
  logic [DEPTH-1:0]             slot_hit;
  match_kind_e                  kind [DEPTH];

  sld_store_table #(
    .TAG_W(TAG_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_tag   (st_tag),
    .st_off   (st_off),
    .st_size  (st_size),
    .grp_end  (grp_end),
    .slot_live(slot_live),
    .slot_tag (slot_tag),
    .slot_off (slot_off),
    .slot_size(slot_size),
    .fill_cnt (fill_cnt)
  );

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      sld_slot_compare #(
        .TAG_W(TAG_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
      ) u_cmp (
        .slot_live(slot_live[gi]),
        .s_tag    (slot_tag[gi]),
        .s_off    (slot_off[gi]),
        .s_size   (slot_size[gi]),
        .l_tag    (ld_tag),
        .l_off    (ld_off),
        .l_size   (ld_size),
        .kind     (kind[gi])
      );
      assign slot_hit[gi] = (kind[gi] != MATCH_NONE);
    end
  endgenerate

  // Combinational hazard: the load query sees the table as of this cycle
  assign noop_req = ld_valid && (|slot_hit);

  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == '0) |-> !noop_req);
endmodule

// File: tb/test_sld_conflict_detector.sv
module test_sld_conflict_detector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, grp_end, ld_valid;
  logic [4:0]  st_tag, ld_tag;
  logic [15:0] st_off, ld_off;
  logic [3:0]  st_size, ld_size;
  logic        noop_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model of the store table
  int m_cnt;
  int m_tag [4];
  int m_off [4];
  int m_size[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sld_conflict_detector i_sld_conflict_detector (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_tag(st_tag), .st_off(st_off), .st_size(st_size),
    .grp_end(grp_end),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_off(ld_off), .ld_size(ld_size),
    .noop_req(noop_req)
  );

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic bit ref_hit(input bit lv, input int lt, input int lo, input int ls);
    bit h = 0;
    if (!lv) return 0;
    for (int i = 0; i < m_cnt; i++) begin
      if (m_tag[i] == lt) begin
        if (m_off[i] == lo) h = 1;
        else if (m_off[i] < lo) begin
          if (m_off[i] + m_size[i] > lo) h = 1;
        end else if (lo + ls > m_off[i]) h = 1;
      end
    end
    return h;
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: noop_req=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational output, then step the model
  task automatic cyc(input bit sv, input int stg, input int so, input int ss,
                     input bit ge, input bit lv, input int ltg, input int lo,
                     input int ls, input int exp, input string req);
    bit e;
    st_valid = sv; st_tag = 5'(stg); st_off = 16'(so); st_size = 4'(ss);
    grp_end = ge;
    ld_valid = lv; ld_tag = 5'(ltg); ld_off = 16'(lo); ld_size = 4'(ls);
    #1;
    e = ref_hit(lv, ltg, sx(16'(lo)), ls);
    if (exp >= 0 && e != exp[0]) begin
      failures++;
      $display("FAIL %s: model=%0b expected=%0b", req, e, exp[0]);
    end
    check(noop_req, (exp >= 0) ? exp[0] : e, req);
    @(posedge clk);
    if (ge) m_cnt = 0;
    else if (sv && m_cnt < 4) begin
      m_tag[m_cnt] = stg; m_off[m_cnt] = sx(16'(so)); m_size[m_cnt] = ss;
      m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, -1, "idle");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    st_valid = 0; grp_end = 0; ld_valid = 0;
    st_tag = 0; st_off = 0; st_size = 0; ld_tag = 0; ld_off = 0; ld_size = 0;
    @(negedge clk);
    do_reset();

    // R8: empty after reset
    cyc(0, 0, 0, 0, 0, 1, 1, 8, 4, 0, "R8 empty after reset");
    // R2: same-cycle store invisible, visible next cycle (R3 exact, R11 same-cycle output)
    cyc(1, 1, 8, 4, 0, 1, 1, 8, 4, 0, "R2 same-cycle store");
    cyc(0, 0, 0, 0, 0, 1, 1, 8, 4, 1, "R3 exact match");
    cyc(0, 0, 0, 0, 0, 1, 1, 9, 1, 1, "R11 combinational follow");
    // R4: store lower, boundary
    cyc(0, 0, 0, 0, 0, 1, 1, 12, 1, 0, "R4 touching above");
    cyc(0, 0, 0, 0, 0, 1, 1, 11, 1, 1, "R4 overlap above");
    // R5: store higher, boundary
    cyc(0, 0, 0, 0, 0, 1, 1, 4, 4, 0, "R5 touching below");
    cyc(0, 0, 0, 0, 0, 1, 1, 4, 5, 1, "R5 overlap below");
    // R6 / R9
    cyc(0, 0, 0, 0, 0, 1, 3, 8, 4, 0, "R6 tag differs");
    cyc(0, 0, 0, 0, 0, 0, 1, 8, 4, 0, "R9 load invalid");
    // R3: zero sizes, exact offsets
    cyc(1, 2, 100, 0, 0, 0, 0, 0, 0, -1, "R3 setup");
    cyc(0, 0, 0, 0, 0, 1, 2, 100, 0, 1, "R3 zero-size exact");
    // R7: load sees old table; store with grp_end dropped
    cyc(1, 5, 0, 4, 1, 1, 1, 8, 4, 1, "R7 load during clear");
    cyc(0, 0, 0, 0, 0, 1, 1, 8, 4, 0, "R7 cleared");
    cyc(0, 0, 0, 0, 0, 1, 5, 0, 4, 0, "R7 store with clear dropped");
    // R1: fifth store dropped
    for (int i = 0; i < 5; i++) cyc(1, i, 0, 4, 0, 0, 0, 0, 0, -1, "R1 fill");
    cyc(0, 0, 0, 0, 0, 1, 4, 0, 4, 0, "R1 fifth store dropped");
    cyc(0, 0, 0, 0, 0, 1, 3, 0, 4, 1, "R1 fourth store kept");
    // R10: no wrap at top of range
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, -1, "R10 clear");
    cyc(1, 0, 32766, 15, 0, 0, 0, 0, 0, -1, "R10 setup");
    cyc(0, 0, 0, 0, 0, 1, 0, 32767, 1, 1, "R10 wide sum overlap");
    cyc(0, 0, 0, 0, 0, 1, 0, -32768, 4, 0, "R10 far negative");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, -1, "R10 clear");
    cyc(1, 0, 32760, 4, 0, 0, 0, 0, 0, -1, "R10 setup high");
    cyc(0, 0, 0, 0, 0, 1, 0, 32757, 15, 1, "R10 load sum past limit");
    // R8: reset mid-group empties table
    cyc(1, 6, 40, 8, 0, 0, 0, 0, 0, -1, "R8 setup");
    do_reset();
    cyc(0, 0, 0, 0, 0, 1, 6, 40, 8, 0, "R8 reset clears");

    // Random traffic over few tags and a narrow offset window
    for (int n = 0; n < 2000; n++) begin
      bit sv = ($urandom_range(0, 2) == 0);
      bit ge = ($urandom_range(0, 6) == 0);
      bit lv = ($urandom_range(0, 3) != 0);
      int base = ($urandom_range(0, 9) == 0) ? 32750 : 0;
      cyc(sv, $urandom_range(0, 2), base + $urandom_range(0, 24) - 12, $urandom_range(0, 15),
          ge, lv, $urandom_range(0, 2), base + $urandom_range(0, 24) - 12, $urandom_range(0, 15),
          -1, "R4/R5 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule